// File: doc/BRIEF.md
# Codec Register Command Slot Interface

This block is the control path through which a host reaches the registers of an external audio codec over an AC-link style controller. The host first loads a data word into the slot-2 transmit register. It then writes a command word into the slot-1 transmit register. That command word carries a direction flag and a 7-bit codec register index. Accepting a slot-1 write starts one access on a request/acknowledge codec register port.

A write access carries the 16-bit value held in slot 2. A read access returns the codec's answer into two receive slot registers and marks them valid.

A flag register reports four kinds of state. It shows whether each transmit slot is empty, whether a command is outstanding, and whether each receive slot holds fresh data. Serial framing of the link and the audio sample path belong to other blocks.

Top module: `acl_cmd_slot`

## Requirements
- R1: After reset the flag word (host address 4) reads 7'b0000111, and `creg_req` is low. The flag bit layout is: bit0 slot-1 transmit empty, bit1 slot-2 transmit empty, bit2 both transmit slots empty, bit3 slot-1 receive busy, bit4 slot-2 receive busy, bit5 slot-1 receive valid, bit6 slot-2 receive valid.
- R2: A host write to address 1 stores the 20-bit word, which then reads back at address 1. The write also clears flag bit1 and flag bit2.
- R3: A host write to address 0 while no request is outstanding stores the command and clears flag bit0. One cycle later `creg_req` is high, `creg_idx` equals command bits 18:12, and `creg_we` is the inverse of command bit 19 (0 means write, 1 means read).
- R4: For a write access, `creg_wdata` equals bits 19:4 of the slot-2 transmit register as it stood when the command was accepted.
- R5: `creg_req`, `creg_idx`, `creg_we` and `creg_wdata` hold steady until a cycle in which `creg_ack` is high. `creg_req` is low in the cycle after that one.
- R6: While a request is outstanding, flag bits 3 and 4 are set. A host write to address 0 during that time is ignored: the slot-1 transmit register (address 0) keeps its old value and no second request is issued.
- R7: When a read access completes, address 2 returns the command word with bit 19 cleared, and address 3 returns `creg_rdata` shifted left by 4. Flag bits 3 and 4 clear, and flag bits 5 and 6 set.
- R8: When any access completes, flag bits 0, 1 and 2 are set again.
- R9: A host read with `rd_en` at address 2 clears flag bit5 only. A host read with `rd_en` at address 3 clears flag bit6 only. Reading with `rd_en` low has no side effect.
- R10: A completed write access leaves addresses 2 and 3 and flag bits 5 and 6 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 3 | Host write address (0 slot-1 tx, 1 slot-2 tx) |
| wr_data | input | 20 | Host write data |
| rd_en | input | 1 | Host read strobe (clears receive valid on addresses 2/3) |
| rd_addr | input | 3 | Host read address (0..4) |
| rd_data | output | 20 | Host read data for `rd_addr`, combinational |
| creg_req | output | 1 | Codec access request |
| creg_idx | output | 7 | Codec register index |
| creg_we | output | 1 | 1 for a write access, 0 for a read access |
| creg_wdata | output | 16 | Codec write data |
| creg_ack | input | 1 | Codec acknowledge, completes the access |
| creg_rdata | input | 16 | Codec read data, valid with `creg_ack` |

## Verification
The assertions assume that the codec raises `creg_ack` only while `creg_req` is high. They also assume that `creg_rdata` is meaningful in the acknowledge cycle. The bench codec model honours both: it acknowledges only an outstanding request, after a chosen latency of zero to three cycles, for exactly one cycle. The host stimulus drives one strobe at a time. It fires slot-1 writes during an outstanding request on purpose, so that the ignore rule is exercised without ever breaking the port protocol.

// File: rtl/acl_cmd_pkg.sv
package acl_cmd_pkg;

    localparam int FLAG_W = 7;

    typedef enum logic [2:0] {
        HA_S1_TX = 3'd0,
        HA_S2_TX = 3'd1,
        HA_S1_RX = 3'd2,
        HA_S2_RX = 3'd3,
        HA_FLAGS = 3'd4
    } host_addr_e;

    // bit 0 is the last member
    typedef struct packed {
        logic s2_valid;
        logic s1_valid;
        logic s2_busy;
        logic s1_busy;
        logic both_empty;
        logic s2_empty;
        logic s1_empty;
    } slot_flags_t;

endpackage

// File: rtl/acl_cmd_engine.sv
module acl_cmd_engine #(
    parameter int SLOT_W = 20,
    parameter int IDX_W  = 7,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [SLOT_W-1:0] cmd_word,
    input  logic [SLOT_W-1:0] data_word,
    input  logic              ack,
    input  logic [DATA_W-1:0] rdata,
    output logic              req,
    output logic [IDX_W-1:0]  idx,
    output logic              we,
    output logic [DATA_W-1:0] wdata,
    output logic              done,
    output logic              done_rd,
    output logic [SLOT_W-1:0] rx1_word,
    output logic [SLOT_W-1:0] rx2_word
);
    localparam int RW_BIT  = SLOT_W - 1;
    localparam int IDX_LSB = RW_BIT - IDX_W;
    localparam int DAT_LSB = SLOT_W - DATA_W;

    typedef struct packed {
        logic              req;
        logic [IDX_W-1:0]  idx;
        logic              we;
        logic [DATA_W-1:0] wdata;
        logic [SLOT_W-1:0] cmd;
    } eng_t;

    eng_t eng_d, eng_q;

    always_comb begin
        eng_d = eng_q;
        if (eng_q.req && ack) begin
            eng_d.req = 1'b0;
        end else if (!eng_q.req && launch) begin
            eng_d.req   = 1'b1;
            eng_d.idx   = cmd_word[RW_BIT-1:IDX_LSB];
            eng_d.we    = ~cmd_word[RW_BIT];
            eng_d.wdata = data_word[SLOT_W-1:DAT_LSB];
            eng_d.cmd   = cmd_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    always_comb begin
        rx1_word         = eng_q.cmd;
        rx1_word[RW_BIT] = 1'b0;
        rx2_word         = SLOT_W'(rdata) << DAT_LSB;
    end

    assign req     = eng_q.req;
    assign idx     = eng_q.idx;
    assign we      = eng_q.we;
    assign wdata   = eng_q.wdata;
    assign done    = eng_q.req && ack;
    assign done_rd = eng_q.req && ack && !eng_q.we;

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack) |=> (req && $stable(idx) && $stable(we) && $stable(wdata)));

    assert_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ack) |=> !req);

endmodule

// File: rtl/acl_slot_flags.sv
module acl_slot_flags
    import acl_cmd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_s1,
    input  logic        wr_s2,
    input  logic        launch,
    input  logic        done,
    input  logic        done_rd,
    input  logic        rd_clr1,
    input  logic        rd_clr2,
    output slot_flags_t flags_o
);
    typedef struct packed {
        logic s1e;
        logic s2e;
        logic s1b;
        logic s2b;
        logic s1v;
        logic s2v;
    } flg_t;

    flg_t flg_d, flg_q;

    always_comb begin
        flg_d = flg_q;
        if (done) begin
            flg_d.s1e = 1'b1;
            flg_d.s2e = 1'b1;
            flg_d.s1b = 1'b0;
            flg_d.s2b = 1'b0;
        end
        if (launch) begin
            flg_d.s1b = 1'b1;
            flg_d.s2b = 1'b1;
        end
        if (wr_s1) flg_d.s1e = 1'b0;
        if (wr_s2) flg_d.s2e = 1'b0;
        if (rd_clr1) flg_d.s1v = 1'b0;
        if (rd_clr2) flg_d.s2v = 1'b0;
        if (done_rd) begin
            flg_d.s1v = 1'b1;
            flg_d.s2v = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flg_q <= '{s1e: 1'b1, s2e: 1'b1, default: 1'b0};
        else        flg_q <= flg_d;
    end

    always_comb begin
        flags_o.s1_empty   = flg_q.s1e;
        flags_o.s2_empty   = flg_q.s2e;
        flags_o.both_empty = flg_q.s1e & flg_q.s2e;
        flags_o.s1_busy    = flg_q.s1b;
        flags_o.s2_busy    = flg_q.s2b;
        flags_o.s1_valid   = flg_q.s1v;
        flags_o.s2_valid   = flg_q.s2v;
    end

    assert_rdclr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr1 && !done_rd) |=> !flags_o.s1_valid);

endmodule

// File: rtl/acl_cmd_slot.sv
module acl_cmd_slot
    import acl_cmd_pkg::*;
#(
    parameter int SLOT_W = 20,
    parameter int IDX_W  = 7,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [SLOT_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [2:0]        rd_addr,
    output logic [SLOT_W-1:0] rd_data,
    output logic              creg_req,
    output logic [IDX_W-1:0]  creg_idx,
    output logic              creg_we,
    output logic [DATA_W-1:0] creg_wdata,
    input  logic              creg_ack,
    input  logic [DATA_W-1:0] creg_rdata
);
    typedef struct packed {
        logic [SLOT_W-1:0] s1tx;
        logic [SLOT_W-1:0] s2tx;
        logic [SLOT_W-1:0] s1rx;
        logic [SLOT_W-1:0] s2rx;
    } slot_regs_t;

    slot_regs_t  reg_d, reg_q;
    slot_flags_t flags;
    logic        accept1, wr2, done, done_rd, clr1, clr2;
    logic [SLOT_W-1:0] rx1_word, rx2_word;

    assign accept1 = wr_en && (wr_addr == HA_S1_TX) && !creg_req;
    assign wr2     = wr_en && (wr_addr == HA_S2_TX);
    assign clr1    = rd_en && (rd_addr == HA_S1_RX);
    assign clr2    = rd_en && (rd_addr == HA_S2_RX);

    acl_cmd_engine #(.SLOT_W(SLOT_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (accept1),
        .cmd_word  (wr_data),
        .data_word (reg_q.s2tx),
        .ack       (creg_ack),
        .rdata     (creg_rdata),
        .req       (creg_req),
        .idx       (creg_idx),
        .we        (creg_we),
        .wdata     (creg_wdata),
        .done      (done),
        .done_rd   (done_rd),
        .rx1_word  (rx1_word),
        .rx2_word  (rx2_word)
    );

    acl_slot_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_s1   (accept1),
        .wr_s2   (wr2),
        .launch  (accept1),
        .done    (done),
        .done_rd (done_rd),
        .rd_clr1 (clr1),
        .rd_clr2 (clr2),
        .flags_o (flags)
    );

    always_comb begin
        reg_d = reg_q;
        if (accept1) reg_d.s1tx = wr_data;
        if (wr2)     reg_d.s2tx = wr_data;
        if (done_rd) begin
            reg_d.s1rx = rx1_word;
            reg_d.s2rx = rx2_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) reg_q <= '0;
        else        reg_q <= reg_d;
    end

    always_comb begin
        case (rd_addr)
            HA_S1_TX: rd_data = reg_q.s1tx;
            HA_S2_TX: rd_data = reg_q.s2tx;
            HA_S1_RX: rd_data = reg_q.s1rx;
            HA_S2_RX: rd_data = reg_q.s2rx;
            HA_FLAGS: rd_data = SLOT_W'(flags);
            default:  rd_data = '0;
        endcase
    end

    assert_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        creg_req |-> (flags.s1_busy && flags.s2_busy));

    assert_ignore_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == HA_S1_TX && creg_req) |=> $stable(reg_q.s1tx));

    assert_rdvalid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (creg_req && creg_ack && !creg_we) |=>
            (flags.s1_valid && flags.s2_valid && !flags.s1_busy && !flags.s2_busy));

    assert_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (creg_req && creg_ack && !wr2) |=> (flags.s1_empty && flags.s2_empty));

    assert_wrkeep_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (creg_req && creg_ack && creg_we) |=> ($stable(reg_q.s1rx) && $stable(reg_q.s2rx)));

endmodule

// File: tb/acl_cmd_slot_tb.sv
module acl_cmd_slot_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [19:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [2:0]  rd_addr = '0;
    logic [19:0] rd_data;
    logic        creg_req;
    logic [6:0]  creg_idx;
    logic        creg_we;
    logic [15:0] creg_wdata;
    logic        creg_ack = 1'b0;
    logic [15:0] creg_rdata = '0;

    int n_checks = 0;
    int n_fail   = 0;
    int lat      = 0;
    int cnt      = 0;
    bit finished = 0;
    logic [15:0] cmem [128];
    logic [23:0] exp_q [$];   // {we, idx, data}

    always #10 clk = ~clk;

    acl_cmd_slot dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .creg_req(creg_req), .creg_idx(creg_idx), .creg_we(creg_we), .creg_wdata(creg_wdata),
        .creg_ack(creg_ack), .creg_rdata(creg_rdata)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // codec register file model
    always @(negedge clk) begin
        if (creg_ack) creg_ack = 1'b0;
        else if (creg_req) begin
            if (cnt >= lat) begin
                creg_ack   = 1'b1;
                creg_rdata = cmem[creg_idx];
                if (creg_we) cmem[creg_idx] = creg_wdata;
                cnt = 0;
            end else cnt++;
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        #1;
        if (creg_req && creg_ack) begin
            logic [23:0] e;
            if (exp_q.size() == 0) begin
                check(0, "R6 unexpected request", {creg_we, creg_idx, creg_wdata}, 0);
            end else begin
                e = exp_q.pop_front();
                check(creg_we == e[23] && creg_idx == e[22:16], "R3 idx/dir",
                      {creg_we, creg_idx}, e[23:16]);
                if (e[23]) check(creg_wdata == e[15:0], "R4 wdata", creg_wdata, e[15:0]);
            end
        end
    end

    task automatic hw(input logic [2:0] a, input logic [19:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [19:0] d);
        rd_addr = a; #1 d = rd_data;
    endtask

    task automatic hr(input logic [2:0] a, output logic [19:0] d);
        rd_en = 1'b1; rd_addr = a; #1 d = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wait_idle();
        while (creg_req) @(negedge clk);
    endtask

    task automatic codec_write(input logic [6:0] i, input logic [15:0] d);
        exp_q.push_back({1'b1, i, d});
        hw(3'd1, {d, 4'h0});
        hw(3'd0, {1'b0, i, 12'h000});
        wait_idle();
    endtask

    task automatic codec_read(input logic [6:0] i, input logic [15:0] expd);
        logic [19:0] v;
        exp_q.push_back({1'b0, i, 16'h0});
        hw(3'd0, {1'b1, i, 12'h000});
        wait_idle();
        peek(3'd2, v); check(v == {1'b0, i, 12'h000}, "R7 rx slot1", v, {1'b0, i, 12'h000});
        peek(3'd3, v); check(v == {expd, 4'h0}, "R7 rx slot2", v, {expd, 4'h0});
        peek(3'd4, v); check(v[6:3] == 4'b1100, "R7 flags valid/busy", v[6:3], 4'b1100);
    endtask

    initial begin
        logic [19:0] v;
        for (int k = 0; k < 128; k++) cmem[k] = 16'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        peek(3'd4, v); check(v == 20'h00007, "R1 reset flags", v, 20'h7);
        check(creg_req == 1'b0, "R1 req idle", creg_req, 0);

        // R2 slot-2 write
        hw(3'd1, 20'hABCD0);
        peek(3'd1, v); check(v == 20'hABCD0, "R2 slot2 readback", v, 20'hABCD0);
        peek(3'd4, v); check(v[2:0] == 3'b001, "R2 empty flags", v[2:0], 3'b001);

        // R3/R4/R6/R5 write launch with latency and ignored second command
        lat = 3;
        exp_q.push_back({1'b1, 7'd5, 16'hABCD});
        hw(3'd0, {1'b0, 7'd5, 12'h000});
        check(creg_req && creg_idx == 7'd5 && creg_we, "R3 launch", {creg_req, creg_idx, creg_we}, {1'b1, 7'd5, 1'b1});
        check(creg_wdata == 16'hABCD, "R4 wdata port", creg_wdata, 16'hABCD);
        peek(3'd4, v); check(v[6:0] == 7'b0011000, "R6 busy flags", v[6:0], 7'b0011000);
        hw(3'd0, {1'b1, 7'd9, 12'h000});
        peek(3'd0, v); check(v == {1'b0, 7'd5, 12'h000}, "R6 ignored slot1 write", v, {1'b0, 7'd5, 12'h000});
        check(creg_req && creg_idx == 7'd5 && creg_we, "R5 request held", {creg_req, creg_idx}, {1'b1, 7'd5});
        wait_idle();
        peek(3'd4, v); check(v[6:0] == 7'b0000111, "R8 empty after ack", v[6:0], 7'b0000111);
        check(cmem[5] == 16'hABCD, "R4 codec stored", cmem[5], 16'hABCD);

        // R7 read back, R9 valid clears
        codec_read(7'd5, 16'hABCD);
        peek(3'd4, v); check(v[2:0] == 3'b111, "R8 empty after read", v[2:0], 3'b111);
        peek(3'd4, v); check(v[6:5] == 2'b11, "R9 peek no side effect", v[6:5], 2'b11);
        hr(3'd2, v);
        peek(3'd4, v); check(v[6:5] == 2'b10, "R9 clear slot1 valid", v[6:5], 2'b10);
        hr(3'd3, v);
        peek(3'd4, v); check(v[6:5] == 2'b00, "R9 clear slot2 valid", v[6:5], 2'b00);

        // R10 write completion leaves receive side alone
        codec_read(7'd5, 16'hABCD);
        codec_write(7'd6, 16'h1234);
        peek(3'd2, v); check(v == {1'b0, 7'd5, 12'h000}, "R10 rx slot1 kept", v, {1'b0, 7'd5, 12'h000});
        peek(3'd3, v); check(v == 20'hABCD0, "R10 rx slot2 kept", v, 20'hABCD0);
        peek(3'd4, v); check(v[6:5] == 2'b11, "R10 valid kept", v[6:5], 2'b11);

        // round trips, boundary indices and patterns, varied latency
        for (int k = 0; k < 4; k++) begin
            logic [6:0]  ix [4] = '{7'd0, 7'd127, 7'd64, 7'd42};
            logic [15:0] dd [4] = '{16'hFFFF, 16'h0000, 16'h5A5A, 16'hA5C3};
            lat = k;
            codec_write(ix[k], dd[k]);
            codec_read(ix[k], dd[k]);
        end
        check(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);

        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule